// File: doc/BRIEF.md
# Channel-Bit Frame Sync Detector with Lock Protection

This block watches a recovered serial channel-bit stream for the frame synchronisation word. From it, the block derives a steady frame timing that does not trip over a missing or spurious sync. A frame counter runs on the bit-clock enable and predicts where the next sync must end.

While the block is unlocked, every sync it finds restarts that counter. Lock is declared only after a run of syncs that land exactly one frame apart. Once locked, the block accepts a sync only inside a small window around the predicted position. It inserts a frame strobe at the predicted position when no sync arrives there. It gives up lock after a run of inserted strobes.

The outputs are a one-cycle frame-start strobe, a one-cycle flag marking a sync that landed exactly on the prediction, and a lock level. Downstream symbol demodulation uses the strobe as its frame boundary.

Top module: `efs_frame_sync`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, frame_start, sync_match and locked are all 0.
- R2: A sync is the 24-bit sequence, taken oldest bit first: one 0, eleven 1s, eleven 0s, one 1. With BOTH_POL set, the bitwise complement of that sequence is also a sync. The sync is recognised on the clock edge that takes its last bit with bit_en high.
- R3: Cycles with bit_en low change nothing. No strobe is issued, the frame counter holds, and the lock state is unchanged, however long the gap lasts.
- R4: While unlocked, each recognised sync gives a frame_start pulse in the next cycle and restarts the frame count from that bit. With no sync, frame_start pulses once every 588 bits.
- R5: locked rises after 3 consecutive syncs with exactly 588 bits between each pair. It rises in the same cycle as the third sync's frame_start and sync_match pulse. A sync at any other spacing restarts the run at one.
- R6: sync_match pulses, together with frame_start, when a sync's last bit is the 588th bit after the previous frame start.
- R7: While locked, a sync ending 1 to 3 bits before the predicted position is accepted. It gives frame_start with sync_match low, clears the miss count and restarts the frame count.
- R8: While locked, if no sync ends at the predicted position, frame_start is still issued there with sync_match low, and the miss count increases by one.
- R9: While locked, a sync ending 1 to 3 bits after an inserted strobe realigns the frame count to that sync. It issues no second strobe and clears the miss count.
- R10: While locked, a sync ending more than 3 bits from the predicted position has no effect on the strobe, the count or the lock.
- R11: While locked, the 8th consecutive inserted strobe drops locked in the same cycle. Any accepted or realigning sync resets this run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Channel-bit clock enable, one cycle per bit |
| bit_in | input | 1 | Channel bit in NRZ level form, valid with bit_en |
| frame_start | output | 1 | One-cycle frame boundary strobe |
| sync_match | output | 1 | Detected sync coincided with the predicted position |
| locked | output | 1 | Frame timing is locked |

## Verification
The stream is built from frames of deliberately chosen lengths. Exact 588-bit frames separate lock acquisition from a fixed timeout. A 586-bit frame tells early acceptance apart from rejection. A 590-bit frame tells a late realignment apart from a second strobe. A 593-bit frame followed by a 583-bit frame shows that an out-of-window sync leaves the old grid intact. Inverted-polarity frames exercise the complement pattern. A wrongly spaced sync separates a broken run from a completed one. Runs of frames without a sync, with one good sync placed between them, show that lock drops on the 8th miss and that an accepted sync resets the count. A long idle gap with bit_en low, and bit pacing with and without gaps, show that only enabled bits advance the timing.

// File: rtl/efs_pkg.sv
package efs_pkg;

   // Position of the next bit relative to the predicted frame boundary
   typedef enum logic [1:0] {
      WIN_OUT   = 2'd0,
      WIN_EARLY = 2'd1,
      WIN_EXACT = 2'd2,
      WIN_LATE  = 2'd3
   } win_cls_e;

endpackage

// File: rtl/efs_pattern_det.sv
module efs_pattern_det #(
   parameter int RUN_LEN  = 11,
   parameter bit BOTH_POL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic det
);
   localparam int SYNC_LEN = 2 * RUN_LEN + 2;
   localparam logic [SYNC_LEN-1:0] PAT =
      {1'b0, {RUN_LEN{1'b1}}, {RUN_LEN{1'b0}}, 1'b1};

   logic [SYNC_LEN-2:0] hist_q;
   logic [SYNC_LEN-1:0] view_w;
   logic                hit_pos;
   logic                hit_neg;

   assign view_w  = {hist_q, bit_in};
   assign hit_pos = (view_w == PAT);

   generate
      if (BOTH_POL) begin : g_both
         assign hit_neg = (view_w == ~PAT);
      end else begin : g_single
         assign hit_neg = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q <= '0;
      else if (bit_en) hist_q <= view_w[SYNC_LEN-2:0];
   end

   assign det = bit_en & (hit_pos | hit_neg);

   // R2
   no_adjacent_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det |=> !det);

endmodule

// File: rtl/efs_bit_counter.sv
module efs_bit_counter #(
   parameter int FRAME_BITS = 588
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_en,
   input  logic                          load,
   output logic [$clog2(FRAME_BITS)-1:0] npos
);
   localparam int PW = $clog2(FRAME_BITS);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

   logic [PW-1:0] pos_q;

   assign npos = (pos_q == LAST) ? '0 : pos_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q <= '0;
      else if (bit_en) pos_q <= load ? '0 : npos;
   end

   // R4
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST);

   // R3
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(pos_q));

endmodule

// File: rtl/efs_window.sv
module efs_window
   import efs_pkg::*;
#(
   parameter int FRAME_BITS = 588,
   parameter int WIN        = 3
) (
   input  logic [$clog2(FRAME_BITS)-1:0] npos,
   output win_cls_e                      cls
);
   generate
      if (WIN > 0) begin : g_win
         always_comb begin
            if (npos == '0)                        cls = WIN_EXACT;
            else if (int'(npos) <= WIN)            cls = WIN_LATE;
            else if (int'(npos) >= FRAME_BITS-WIN) cls = WIN_EARLY;
            else                                   cls = WIN_OUT;
         end
      end else begin : g_exact
         always_comb cls = (npos == '0) ? WIN_EXACT : WIN_OUT;
      end
   endgenerate

endmodule

// File: rtl/efs_lock_ctrl.sv
module efs_lock_ctrl
   import efs_pkg::*;
#(
   parameter int LOCK_HITS = 3,
   parameter int MISS_MAX  = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bit_en,
   input  logic     det,
   input  win_cls_e cls,
   output logic     load,
   output logic     frame_start,
   output logic     sync_match,
   output logic     locked
);
   localparam int HW = $clog2(LOCK_HITS + 1);
   localparam int MW = $clog2(MISS_MAX + 1);

   logic [HW-1:0] hit_q, hit_d;
   logic [MW-1:0] miss_q, miss_inc;
   logic          locked_q, pend_q, fs_q, sm_q;
   logic          on_grid, acq, free_wrap, accept, realign, insert;
   logic          lock_now, drop;

   always_comb begin
      on_grid   = det && (cls == WIN_EXACT);
      acq       = !locked_q && det;
      free_wrap = !locked_q && bit_en && !det && (cls == WIN_EXACT);
      accept    = locked_q && det && (cls == WIN_EARLY || cls == WIN_EXACT);
      realign   = locked_q && det && (cls == WIN_LATE) && pend_q;
      insert    = locked_q && bit_en && !det && (cls == WIN_EXACT);
      hit_d     = (on_grid && hit_q != '0) ? hit_q + 1'b1 : HW'(1);
      lock_now  = acq && (hit_d == HW'(LOCK_HITS));
      miss_inc  = miss_q + 1'b1;
      drop      = insert && (miss_inc == MW'(MISS_MAX));
   end

   assign load = acq | accept | realign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q    <= '0;
         miss_q   <= '0;
         locked_q <= 1'b0;
         pend_q   <= 1'b0;
         fs_q     <= 1'b0;
         sm_q     <= 1'b0;
      end else begin
         fs_q <= acq | accept | insert | free_wrap;
         sm_q <= on_grid;
         if (!locked_q) begin
            pend_q <= 1'b0;
            if (acq)            hit_q <= lock_now ? '0 : hit_d;
            else if (free_wrap) hit_q <= '0;
            if (lock_now) begin
               locked_q <= 1'b1;
               miss_q   <= '0;
            end
         end else begin
            if (accept || realign) begin
               miss_q <= '0;
               pend_q <= 1'b0;
            end else if (insert) begin
               if (drop) begin
                  locked_q <= 1'b0;
                  miss_q   <= '0;
                  pend_q   <= 1'b0;
               end else begin
                  miss_q <= miss_inc;
                  pend_q <= 1'b1;
               end
            end else if (bit_en && cls == WIN_OUT) begin
               pend_q <= 1'b0;
            end
         end
      end
   end

   assign frame_start = fs_q;
   assign sync_match  = sm_q;
   assign locked      = locked_q;

   // R5
   lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> sm_q);

   // R11
   lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> (fs_q && !sm_q));

   // R6
   match_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sm_q |-> fs_q);

   // R11
   miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q < MW'(MISS_MAX));

   // R3
   strobe_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_q |-> $past(bit_en));

endmodule

// File: rtl/efs_frame_sync.sv
module efs_frame_sync
   import efs_pkg::*;
#(
   parameter int RUN_LEN    = 11,
   parameter int FRAME_BITS = 588,
   parameter int WIN        = 3,
   parameter int LOCK_HITS  = 3,
   parameter int MISS_MAX   = 8,
   parameter bit BOTH_POL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic frame_start,
   output logic sync_match,
   output logic locked
);
   localparam int SYNC_LEN = 2 * RUN_LEN + 2;
   localparam int PW       = $clog2(FRAME_BITS);

   generate
      if (RUN_LEN < 2)
         $error("RUN_LEN must be at least 2");
      if (FRAME_BITS < 2 * SYNC_LEN)
         $error("FRAME_BITS must hold at least two sync words");
      if (WIN < 0 || 2 * WIN + 1 >= SYNC_LEN)
         $error("WIN must be non-negative and narrower than a sync word");
      if (LOCK_HITS < 1 || MISS_MAX < 1)
         $error("LOCK_HITS and MISS_MAX must be at least 1");
   endgenerate

   logic          det;
   logic          load;
   logic [PW-1:0] npos;
   win_cls_e      cls;

   efs_pattern_det #(.RUN_LEN(RUN_LEN), .BOTH_POL(BOTH_POL)) u_det (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .det(det)
   );

   efs_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load), .npos(npos)
   );

   efs_window #(.FRAME_BITS(FRAME_BITS), .WIN(WIN)) u_win (
      .npos(npos), .cls(cls)
   );

   efs_lock_ctrl #(.LOCK_HITS(LOCK_HITS), .MISS_MAX(MISS_MAX)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .det(det), .cls(cls),
      .load(load), .frame_start(frame_start), .sync_match(sync_match),
      .locked(locked)
   );

endmodule

// File: tb/efs_frame_sync_tb.sv
module efs_frame_sync_tb;
   localparam int L  = 588;
   localparam int SL = 24;
   localparam int W  = 3;

   logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
   logic fs, sm, lk;
   int checks = 0, errors = 0, gap = 0, fs_cnt = 0, sm_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   efs_frame_sync u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .frame_start(fs), .sync_match(sm), .locked(lk)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   bit hq[$];
   int m_pos, m_hit, m_miss, np, off;
   bit m_lk, m_pend, e_fs, e_sm, pa, pb, d, want;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pos = 0; m_hit = 0; m_miss = 0; m_lk = 0; m_pend = 0;
         e_fs = 0; e_sm = 0;
         hq = {};
         for (int i = 0; i < SL; i++) hq.push_back(1'b0);
      end else begin
         e_fs = 0; e_sm = 0;
         if (bit_en) begin
            hq.push_back(bit_in);
            void'(hq.pop_front());
            pa = 1; pb = 1;
            for (int i = 0; i < SL; i++) begin
               want = (i == 0) ? 1'b0 : (i <= 11) ? 1'b1 : (i <= 22) ? 1'b0 : 1'b1;
               if (hq[i] != want) pa = 0;
               if (hq[i] == want) pb = 0;
            end
            d  = pa | pb;
            np = (m_pos + 1) % L;
            if (np == 0)           off = 0;
            else if (np <= W)      off = np;
            else if (np >= L - W)  off = np - L;
            else                   off = 99;
            if (!m_lk) begin
               if (d) begin
                  e_fs = 1; e_sm = (np == 0);
                  m_hit = (np == 0 && m_hit > 0) ? m_hit + 1 : 1;
                  m_pos = 0;
                  if (m_hit == 3) begin m_lk = 1; m_hit = 0; m_miss = 0; m_pend = 0; end
               end else begin
                  m_pos = np;
                  if (np == 0) begin e_fs = 1; m_hit = 0; end
               end
            end else begin
               if (d && off <= 0 && off >= -W) begin
                  e_fs = 1; e_sm = (off == 0); m_pos = 0; m_miss = 0; m_pend = 0;
               end else if (d && off > 0 && off <= W && m_pend) begin
                  m_pos = 0; m_miss = 0; m_pend = 0;
               end else begin
                  m_pos = np;
                  if (np == 0) begin
                     e_fs = 1; m_miss++; m_pend = 1;
                     if (m_miss == 8) begin m_lk = 0; m_miss = 0; m_pend = 0; end
                  end else if (off == 99) m_pend = 0;
               end
            end
         end
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 frame_start vs model", int'(fs), int'(e_fs));
         chk("R6 sync_match vs model", int'(sm), int'(e_sm));
         chk("R5 locked vs model", int'(lk), int'(m_lk));
      end
   end

   always @(posedge clk) begin
      if (fs) fs_cnt++;
      if (sm) sm_cnt++;
   end

   // ---------------- stimulus ----------------
   task automatic send_bit(input bit b);
      bit_in = b; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic filler(input int n);
      for (int i = 0; i < n; i++) send_bit(((i / 3) % 2) == 1);
   endtask

   task automatic frame(input int len, input bit has_sync, input bit inv);
      if (!has_sync) filler(len);
      else begin
         filler(len - SL);
         for (int i = 0; i < SL; i++)
            send_bit(inv ^ ((i == 0) ? 1'b0 : (i <= 11) ? 1'b1 : (i <= 22) ? 1'b0 : 1'b1));
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic zero();
      fs_cnt = 0; sm_cnt = 0;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 frame_start in reset", int'(fs), 0);
      chk("R1 sync_match in reset", int'(sm), 0);
      chk("R1 locked in reset", int'(lk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 frame_start after reset", int'(fs), 0);
      chk("R1 locked after reset", int'(lk), 0);

      // acquisition
      filler(100);
      frame(L, 1, 0);
      frame(L, 1, 0);
      chk("R5 not locked after two syncs", int'(lk), 0);
      frame(L, 1, 0);
      chk("R5 locked after third sync", int'(lk), 1);

      // on-grid syncs
      zero(); frame(L, 1, 0); frame(L, 1, 0);
      chk("R6 matches on grid", sm_cnt, 2);
      chk("R6 strobes on grid", fs_cnt, 2);

      // early sync, with bit gaps
      gap = 1;
      zero(); frame(L - 2, 1, 0);
      chk("R7 early strobe", fs_cnt, 1);
      chk("R7 early no match", sm_cnt, 0);
      chk("R7 still locked", int'(lk), 1);
      zero(); frame(L, 1, 0);
      chk("R7 regrid after early", sm_cnt, 1);

      // late sync
      zero(); frame(L + 2, 1, 0);
      chk("R8 inserted strobe only", fs_cnt, 1);
      chk("R8 inserted no match", sm_cnt, 0);
      zero(); frame(L, 1, 0);
      chk("R9 realigned to late sync", sm_cnt, 1);
      chk("R9 single strobe", fs_cnt, 1);
      gap = 0;

      // out-of-window sync ignored
      zero(); frame(L + 5, 1, 0);
      chk("R10 one strobe", fs_cnt, 1);
      chk("R10 no match", sm_cnt, 0);
      zero(); frame(L - 5, 1, 0);
      chk("R10 grid kept", sm_cnt, 1);

      // complement polarity
      zero(); frame(L, 1, 1); frame(L, 1, 1);
      chk("R2 inverted syncs match", sm_cnt, 2);

      // missing syncs
      for (int k = 0; k < 7; k++) frame(L, 0, 0);
      chk("R11 locked after 7 misses", int'(lk), 1);
      frame(L, 1, 0);
      for (int k = 0; k < 7; k++) frame(L, 0, 0);
      chk("R11 count cleared by sync", int'(lk), 1);
      zero(); frame(L, 0, 0);
      chk("R11 lock dropped on 8th miss", int'(lk), 0);
      chk("R8 inserted strobe on 8th", fs_cnt, 1);

      // unlocked behaviour
      zero(); filler(L); repeat (2) @(negedge clk);
      chk("R4 free-running strobe", fs_cnt, 1);
      zero(); frame(300, 1, 0);
      chk("R4 sync restarts frame", fs_cnt, 1);
      frame(L, 1, 0);
      frame(400, 1, 0);
      chk("R5 wrong spacing no lock", int'(lk), 0);
      frame(L, 1, 0);
      chk("R5 run restarted", int'(lk), 0);
      frame(L, 1, 0);
      chk("R5 relocked", int'(lk), 1);

      // idle enable
      zero(); repeat (2000) @(negedge clk);
      chk("R3 no strobe while idle", fs_cnt, 0);
      chk("R3 lock kept while idle", int'(lk), 1);
      zero(); frame(L, 1, 0);
      chk("R3 grid kept across idle", sm_cnt, 1);

      summary();
      $finish;
   end

endmodule